// File: doc/BRIEF.md
# Carrier Sense, Collision and Heartbeat Pulse Generator

This block sits between a transceiver's activity detectors and the media-independent interface. It turns two internal indications, transmit active and receive active, into the carrier-sense and collision outputs seen by the MAC. Both outputs are registered, so they follow their inputs with one clock of latency.

The block also produces the signal-quality-error test pulse, often called the heartbeat. When transmission ends, the collision line rises briefly after a fixed delay. The delay and the pulse length are counted in clock cycles, and each is set by a parameter. The defaults of 25 and 25 give 1 µs each at a 25 MHz clock. If transmission starts again before the pulse has begun, the pending pulse is dropped. A true collision and the test pulse share the collision line.

Configuration arrives on plain input pins:
- A carrier-rule bit chooses whether carrier sense counts the block's own transmission or only reception.
- A link-select bit picks which of two enable bits governs the heartbeat pulse.

Top module: `carrier_col_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) drives `crs` and `col` low after that edge and cancels any pending or running heartbeat pulse.
- R2: With `crs_rx_only` = 0, `crs` after each rising edge equals `rx_act | tx_act` as sampled at that edge.
- R3: With `crs_rx_only` = 1, `crs` after each rising edge equals `rx_act` as sampled at that edge; transmit activity alone never raises it.
- R4: A true collision term equal to `tx_act & rx_act` sampled at each rising edge appears on `col` after that edge.
- R5: A transmit end is the first rising edge E0 that samples `tx_act` = 0 after an edge that sampled it as 1. If the pulse is enabled, `col` is high from edge E0+SQE_DELAY through edge E0+SQE_DELAY+SQE_WIDTH-1 (SQE_WIDTH cycles) and low from the heartbeat otherwise.
- R6: The enable used at E0 is `sqe_en0` when `link_sel` = 0 and `sqe_en1` when `link_sel` = 1. If the selected enable is 0 at E0, no heartbeat follows that transmit end.
- R7: If `tx_act` is sampled high at any edge from E0+1 through E0+SQE_DELAY, the pending pulse is cancelled. Once the pulse has started, raising `tx_act` does not shorten it.
- R8: The true collision term and the heartbeat pulse are OR-ed, so `col` is high when either is active.
- R9: A new transmit end during a running pulse ends that pulse and restarts the delay from the new edge E0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all timing counts in its cycles |
| rst | input | 1 | Synchronous reset, active high |
| tx_act | input | 1 | Transmit activity indication |
| rx_act | input | 1 | Receive activity indication |
| crs_rx_only | input | 1 | Carrier rule: 1 = receive only, 0 = receive or transmit |
| link_sel | input | 1 | Chooses which heartbeat enable applies (0: `sqe_en0`, 1: `sqe_en1`) |
| sqe_en0 | input | 1 | Heartbeat enable used when `link_sel` = 0 |
| sqe_en1 | input | 1 | Heartbeat enable used when `link_sel` = 1 |
| crs | output | 1 | Carrier sense |
| col | output | 1 | Collision, including the heartbeat pulse |

## Verification
Two events can land in the same cycle: the heartbeat pulse on `col` and a true transmit/receive overlap. The bench sweeps the cycle at which transmit restarts and, separately, the cycle at which receive activity rises, across every offset around the delay and pulse windows. This makes the overlap begin before, during and after the pulse, and also lets a transmit restart meet the final delay cycle. Each cycle's expected `col` is computed as the OR of the arithmetic pulse window, gated by cancellation and the selected enable, with the sampled overlap, and is compared directly against the output.

// File: rtl/carrier_col_gen.sv
module carrier_col_gen #(
  parameter int unsigned SQE_DELAY = 25,
  parameter int unsigned SQE_WIDTH = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_act,
  input  logic rx_act,
  input  logic crs_rx_only,
  input  logic link_sel,
  input  logic sqe_en0,
  input  logic sqe_en1,
  output logic crs,
  output logic col
);
  localparam int unsigned CMAX = (SQE_DELAY > SQE_WIDTH) ? SQE_DELAY : SQE_WIDTH;
  localparam int CW = $clog2(CMAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_PULSE} sqe_st_t;

  sqe_st_t         st;
  logic [CW-1:0]   cnt;
  logic            tx_q, crs_q, coll_q;

  wire tx_fall = tx_q & ~tx_act;
  wire sqe_on  = link_sel ? sqe_en1 : sqe_en0;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      cnt    <= '0;
      tx_q   <= 1'b0;
      crs_q  <= 1'b0;
      coll_q <= 1'b0;
    end else begin
      tx_q   <= tx_act;
      crs_q  <= rx_act | (tx_act & ~crs_rx_only);
      coll_q <= tx_act & rx_act;
      if (tx_fall) begin
        if (sqe_on) begin
          st  <= S_WAIT;
          cnt <= CW'(SQE_DELAY - 1);
        end else begin
          st  <= S_IDLE;
        end
      end else begin
        case (st)
          S_WAIT: begin
            if (tx_act) begin
              st <= S_IDLE;
            end else if (cnt == '0) begin
              st  <= S_PULSE;
              cnt <= CW'(SQE_WIDTH - 1);
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          S_PULSE: begin
            if (cnt == '0) st <= S_IDLE;
            else           cnt <= cnt - 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign crs = crs_q;
  assign col = coll_q | (st == S_PULSE);
endmodule

// File: rtl/carrier_col_gen_chk.sv
module carrier_col_gen_chk (
  input logic clk,
  input logic rst,
  input logic tx_act,
  input logic rx_act,
  input logic crs_rx_only,
  input logic crs,
  input logic col
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= !rst;

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!crs && !col));

  // R2
  crs_follow_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> (crs == ($past(rx_act) | ($past(tx_act) & ~$past(crs_rx_only)))));

  // R3
  crs_rx_only_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(crs_rx_only) && !$past(rx_act)) |-> !crs);

  // R4
  overlap_col_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(tx_act) && $past(rx_act)) |-> col);

  // R5
  col_source_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && col) |-> (($past(tx_act) && $past(rx_act)) || !$past(tx_act) || $past(col)));
endmodule

bind carrier_col_gen carrier_col_gen_chk i_chk (
  .clk(clk), .rst(rst), .tx_act(tx_act), .rx_act(rx_act),
  .crs_rx_only(crs_rx_only), .crs(crs), .col(col)
);

// File: tb/test_carrier_col_gen.sv
module test_carrier_col_gen;
  localparam int PER = 10;
  localparam int D   = 5;
  localparam int W   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_act = 1'b0, rx_act = 1'b0, crs_rx_only = 1'b0;
  logic link_sel = 1'b0, sqe_en0 = 1'b0, sqe_en1 = 1'b0;
  logic crs, col;
  int   vec = 0, err = 0;
  bit   done = 1'b0;

  always #(PER/2) clk = ~clk;

  carrier_col_gen #(.SQE_DELAY(D), .SQE_WIDTH(W)) i_carrier_col_gen (
    .clk(clk), .rst(rst), .tx_act(tx_act), .rx_act(rx_act),
    .crs_rx_only(crs_rx_only), .link_sel(link_sel),
    .sqe_en0(sqe_en0), .sqe_en1(sqe_en1), .crs(crs), .col(col)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic got, logic exp);
    vec++;
    if (got !== exp) begin
      err++;
      $display("FAIL %s at %0t: got %b expected %b", tag, $time, got, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; tx_act = 1'b0; rx_act = 1'b0;
    step();
    rst = 1'b0;
  endtask

  // Sweep: transmit ends at E0, transmit restarts at sample ktx, receive rises at sample krx
  task automatic run(int ktx, int krx, bit sel, bit e0, bit e1, bit ro);
    bit en;
    logic ec, es;
    en = sel ? e1 : e0;
    do_reset();
    link_sel = sel; sqe_en0 = e0; sqe_en1 = e1; crs_rx_only = ro;
    tx_act = 1'b1;
    step();
    chk("R2 R3 crs during tx", crs, !ro);
    step();
    tx_act = 1'b0;
    step();
    for (int j = 0; j <= D + W + 2; j++) begin
      ec = (en && ktx > D && j >= D && j < D + W) || (j >= ktx && j >= krx);
      es = (j >= krx) || (j >= ktx && !ro);
      chk("R4 R5 R6 R7 R8 col", col, ec);
      chk("R2 R3 crs", crs, es);
      if (j + 1 == ktx) tx_act = 1'b1;
      if (j + 1 == krx) rx_act = 1'b1;
      step();
    end
  endtask

  initial begin
    #(PER * 200000);
    if (!done) begin
      err++;
      $display("FAIL watchdog (all requirements): got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec, err);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    @(negedge clk);
    step();
    chk("R1 crs reset", crs, 1'b0);
    chk("R1 col reset", col, 1'b0);
    rst = 1'b0;

    // R2 R3 R4: all input combinations
    for (int v = 0; v < 8; v++) begin
      tx_act = v[0]; rx_act = v[1]; crs_rx_only = v[2];
      step();
      chk("R2 R3 crs combo", crs, v[2] ? v[1] : (v[0] | v[1]));
      chk("R4 col combo", col, v[0] & v[1]);
    end
    tx_act = 1'b0; rx_act = 1'b0;

    // R5..R8 near-exhaustive sweep
    for (int m = 0; m < 16; m++)
      for (int kt = 1; kt <= D + W + 1; kt++)
        for (int kr = 1; kr <= D + W + 3; kr++)
          run(kt, kr, m[0], m[1], m[2], m[3]);

    // R1: reset in mid-pulse clears the pulse
    do_reset();
    link_sel = 1'b0; sqe_en0 = 1'b1; crs_rx_only = 1'b0;
    tx_act = 1'b1; step(); step();
    tx_act = 1'b0; step();
    for (int j = 0; j < D; j++) step();
    chk("R5 pulse before reset", col, 1'b1);
    rst = 1'b1; step();
    chk("R1 col mid-pulse reset", col, 1'b0);
    chk("R1 crs mid-pulse reset", crs, 1'b0);
    rst = 1'b0;
    for (int j = 0; j < D + W + 2; j++) begin
      step();
      chk("R1 pulse cleared", col, 1'b0);
    end

    // R9: new transmit end during a pulse restarts the delay
    do_reset();
    tx_act = 1'b1; step(); step();
    tx_act = 1'b0; step();
    for (int j = 0; j <= 3 * D + 2 * W; j++) begin
      logic ec;
      ec = (j >= D && j < D + 2) || (j >= 2 * D + 2 && j < 2 * D + 2 + W);
      chk("R9 restart col", col, ec);
      tx_act = (j + 1 == D + 1);
      step();
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, err);
    $finish;
  end
endmodule